// File: doc/BRIEF.md
# Acquisition Scan List Sequencer

This block keeps a programmable list of conversion descriptors and walks through it to steer an analog front end. Each descriptor picks one of eight input channels, one of four gain codes and single-ended or differential referencing. It also carries a start flag. The flag decides whether that conversion waits for a pacer tick or runs as soon as the previous conversion completes. With the same list, software can pace every conversion (flag on every entry) or pace whole scans (flag only on the first entry).

A host loads descriptors through one 8-bit write port, as two byte writes per 16-bit descriptor: the low byte goes first, then the high byte. A command port accepts three commands: arm, stop, and queue reset. Once armed, the sequencer presents the selections of the current entry and issues a one-cycle convert strobe. It then waits for the converter's done pulse before it moves on. Completing the last entry raises a sticky end-of-scan event, which can drive an interrupt line. In one-shot mode the sequencer goes idle after one pass. In continuous mode it starts again at entry 0.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, the status byte reads 0x80 (idle), `convert_o` and `irq_o` are low, and the list is empty.
- R2: A descriptor is formed from two successive byte writes on `byte_data_i`, low byte first. In the 16-bit word, bit 14 selects differential mode (0 = ground-referenced), bits 13:12 are the gain code, bits 10:8 are the channel, and bit 7 is the start flag. During the conversion of that entry, `chan_o`, `gain_o` and `diff_o` show the stored fields.
- R3: A command byte with bit 5 (0x20) set empties the list, rewinds the write position and makes the next data byte a low byte. A stray low byte written before this command has no effect on the entries loaded after it.
- R4: A command byte with bit 7 (0x80) set starts a pass at entry 0. Status bit 6 (0x40) is set while the sequencer is active, and bit 7 (0x80) is set otherwise. Arming an empty list leaves the sequencer idle.
- R5: An entry with the start flag set does not convert until a `pacer_tick_i` pulse arrives. Its strobe appears in the cycle after the tick is sampled.
- R6: An entry without the start flag converts after the previous conversion's `adc_done_i`, with no pacer tick.
- R7: `convert_o` is high for exactly one cycle per conversion. The selections stay unchanged from the strobe until the matching done pulse.
- R8: The done pulse of the last entry sets status bit 4 (0x10). The bit stays set until `status_ack_i` or an arm command clears it. `irq_o` equals that bit ANDed with `eos_irq_en_i`.
- R9: With `continuous_i` low, the sequencer returns to idle after one pass. With it high, the sequencer wraps to entry 0 and keeps stepping.
- R10: A command byte with bit 4 (0x10) set returns the sequencer to idle at once, and no further strobes occur.
- R11: Once the list holds DEPTH entries, further descriptor writes are dropped and the pass covers only the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr_i | input | 1 | Descriptor byte write strobe |
| byte_data_i | input | 8 | Descriptor byte (low, then high) |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_data_i | input | 8 | Command byte: 0x80 arm, 0x20 queue reset, 0x10 stop |
| continuous_i | input | 1 | 1 = wrap after the last entry, 0 = single pass |
| eos_irq_en_i | input | 1 | End-of-scan interrupt enable |
| status_ack_i | input | 1 | Clears the end-of-scan event |
| pacer_tick_i | input | 1 | Pacer tick pulse |
| adc_done_i | input | 1 | Converter finished pulse |
| chan_o | output | 3 | Selected input channel |
| gain_o | output | 2 | Gain code: 0 ±10 V, 1 ±5 V, 2 ±2.5 V, 3 ±1.25 V |
| diff_o | output | 1 | Differential reference select |
| convert_o | output | 1 | Convert strobe |
| status_o | output | 8 | Bit 7 idle, bit 6 running, bit 4 end-of-scan |
| irq_o | output | 1 | End-of-scan interrupt |

## Verification
The assertions check several properties on every cycle:
- the convert strobe is a single-cycle pulse;
- the selections stay frozen while a conversion is in flight;
- a start-flagged conversion is always preceded by a sampled pacer tick;
- the list count never goes past its depth;
- the end-of-scan event only ever rises on a done pulse;
- the read position stays inside the loaded list.

Other behaviours need the bench's scenarios, because they depend on sequences of stimulus:
- the byte order of descriptor assembly;
- the re-alignment of the byte phase after a queue reset;
- the wrap in continuous mode against the stop in one-shot mode;
- the dropping of writes to a full list;
- the silence after a stop command.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int WORD_W       = 16;
    localparam int CMD_STOP_BIT = 4;
    localparam int CMD_QRST_BIT = 5;
    localparam int CMD_ARM_BIT  = 7;

    typedef struct packed {
        logic       diff;
        logic [1:0] gain;
        logic [2:0] chan;
        logic       start;
    } scan_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_TICK,
        ST_CONVERT,
        ST_WAIT_DONE
    } step_state_t;

    function automatic scan_sel_t decode_entry(input logic [WORD_W-1:0] w);
        scan_sel_t s;
        s.diff  = w[14];
        s.gain  = w[13:12];
        s.chan  = w[10:8];
        s.start = w[7];
        return s;
    endfunction

endpackage

// File: rtl/scan_loader.sv
module scan_loader
    import scan_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_wr,
    input  logic [7:0]        byte_data,
    input  logic              q_reset,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_word,
    output logic [CW-1:0]     count
);

    logic       hi_phase;
    logic [7:0] low_hold;
    logic       has_room;

    assign has_room = (count < CW'(DEPTH));
    assign wr_en    = byte_wr && hi_phase && !q_reset && has_room;
    assign wr_addr  = count[AW-1:0];
    assign wr_word  = {byte_data, low_hold};

    always_ff @(posedge clk) begin
        if (rst || q_reset) begin
            hi_phase <= 1'b0;
            low_hold <= '0;
            count    <= '0;
        end else if (byte_wr) begin
            if (!hi_phase) begin
                low_hold <= byte_data;
                hi_phase <= 1'b1;
            end else begin
                hi_phase <= 1'b0;
                if (has_room) count <= count + 1'b1;
            end
        end
    end

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3
    qreset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        q_reset |=> (count == '0 && !wr_en));

endmodule

// File: rtl/scan_store.sv
module scan_store
    import scan_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/scan_stepper.sv
module scan_stepper
    import scan_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          halt,
    input  logic [CW-1:0] count,
    input  logic          continuous,
    input  scan_sel_t     entry,
    input  logic          pacer_tick,
    input  logic          adc_done,
    output logic [AW-1:0] rd_addr,
    output scan_sel_t     sel,
    output logic          convert,
    output logic          running,
    output logic          eos_pulse
);

    step_state_t state;
    logic [AW-1:0] ptr;
    logic          last;

    assign last      = ((CW'(ptr) + 1'b1) == count);
    assign rd_addr   = ptr;
    assign convert   = (state == ST_CONVERT);
    assign running   = (state != ST_IDLE);
    assign eos_pulse = (state == ST_WAIT_DONE) && adc_done && last && !halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr   <= '0;
            sel   <= '0;
        end else if (halt) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arm && count != '0) begin
                        ptr   <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    sel   <= entry;
                    state <= entry.start ? ST_WAIT_TICK : ST_CONVERT;
                end
                ST_WAIT_TICK: begin
                    if (pacer_tick) state <= ST_CONVERT;
                end
                ST_CONVERT: state <= ST_WAIT_DONE;
                ST_WAIT_DONE: begin
                    if (adc_done) begin
                        if (last) begin
                            ptr   <= '0;
                            state <= continuous ? ST_FETCH : ST_IDLE;
                        end else begin
                            ptr   <= ptr + 1'b1;
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    tick_before_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (convert && sel.start) |-> $past(pacer_tick));

    // R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        convert |=> !convert);

    // R7
    sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_DONE) |-> $stable(sel));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (CW'(ptr) < count));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_wr_i,
    input  logic [7:0] byte_data_i,
    input  logic       cmd_wr_i,
    input  logic [7:0] cmd_data_i,
    input  logic       continuous_i,
    input  logic       eos_irq_en_i,
    input  logic       status_ack_i,
    input  logic       pacer_tick_i,
    input  logic       adc_done_i,
    output logic [2:0] chan_o,
    output logic [1:0] gain_o,
    output logic       diff_o,
    output logic       convert_o,
    output logic [7:0] status_o,
    output logic       irq_o
);

    logic              q_reset, cmd_stop, cmd_arm;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [WORD_W-1:0] wr_word, rd_word;
    logic [CW-1:0]     count;
    scan_sel_t         sel;
    logic              running, eos_pulse, eos_flag;

    assign q_reset  = cmd_wr_i && cmd_data_i[CMD_QRST_BIT];
    assign cmd_stop = cmd_wr_i && cmd_data_i[CMD_STOP_BIT];
    assign cmd_arm  = cmd_wr_i && cmd_data_i[CMD_ARM_BIT];

    scan_loader #(.DEPTH(DEPTH)) u_loader (
        .clk       (clk),
        .rst       (rst),
        .byte_wr   (byte_wr_i),
        .byte_data (byte_data_i),
        .q_reset   (q_reset),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .count     (count)
    );

    scan_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    scan_stepper #(.DEPTH(DEPTH)) u_stepper (
        .clk        (clk),
        .rst        (rst),
        .arm        (cmd_arm),
        .halt       (cmd_stop || q_reset),
        .count      (count),
        .continuous (continuous_i),
        .entry      (decode_entry(rd_word)),
        .pacer_tick (pacer_tick_i),
        .adc_done   (adc_done_i),
        .rd_addr    (rd_addr),
        .sel        (sel),
        .convert    (convert_o),
        .running    (running),
        .eos_pulse  (eos_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)                           eos_flag <= 1'b0;
        else if (eos_pulse)                eos_flag <= 1'b1;
        else if (status_ack_i || cmd_arm)  eos_flag <= 1'b0;
    end

    assign chan_o   = sel.chan;
    assign gain_o   = sel.gain;
    assign diff_o   = sel.diff;
    assign status_o = {!running, running, 1'b0, eos_flag, 4'b0000};
    assign irq_o    = eos_flag && eos_irq_en_i;

    // R8
    eos_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eos_flag) |-> $past(adc_done_i));

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> (!running && !convert_o));

endmodule

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_wr_i = 0, cmd_wr_i = 0;
    logic [7:0] byte_data_i = 0, cmd_data_i = 0;
    logic       continuous_i = 0, eos_irq_en_i = 0, status_ack_i = 0;
    logic       pacer_tick_i = 0, adc_done_i = 0;
    logic [2:0] chan_o;
    logic [1:0] gain_o;
    logic       diff_o, convert_o, irq_o;
    logic [7:0] status_o;

    scan_sequencer #(.DEPTH(DEPTH)) u_scan_sequencer (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    int conv_n = 0;
    int wide_err = 0, drift_err = 0;
    logic [5:0] log_sel [64];
    logic prev_conv = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic d, input logic [1:0] g,
                                        input logic [2:0] c, input logic s);
        return {1'b0, d, g, 1'b0, c, s, 7'b0};
    endfunction

    function automatic logic [5:0] pk(input logic d, input logic [1:0] g,
                                      input logic [2:0] c);
        return {d, g, c};
    endfunction

    // conversion monitor
    initial forever begin
        @(negedge clk);
        if (convert_o) begin
            if (conv_n < 64) log_sel[conv_n] = {diff_o, gain_o, chan_o};
            conv_n++;
            if (prev_conv) wide_err++;
        end
        prev_conv = convert_o;
    end

    // converter model: done two cycles after the strobe
    initial forever begin
        @(negedge clk);
        if (convert_o) begin
            repeat (2) @(negedge clk);
            if ({diff_o, gain_o, chan_o} != log_sel[(conv_n - 1) % 64]) drift_err++;
            adc_done_i = 1;
            @(negedge clk);
            adc_done_i = 0;
        end
    end

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); byte_wr_i = 1; byte_data_i = b;
        @(negedge clk); byte_wr_i = 0;
    endtask

    task automatic put_entry(input logic [15:0] w);
        put_byte(w[7:0]);
        put_byte(w[15:8]);
    endtask

    task automatic command(input logic [7:0] c);
        @(negedge clk); cmd_wr_i = 1; cmd_data_i = c;
        @(negedge clk); cmd_wr_i = 0;
    endtask

    task automatic tick();
        @(negedge clk); pacer_tick_i = 1;
        @(negedge clk); pacer_tick_i = 0;
    endtask

    task automatic ack();
        @(negedge clk); status_ack_i = 1;
        @(negedge clk); status_ack_i = 0;
    endtask

    task automatic wait_conv(input int n);
        for (int i = 0; i < 200 && conv_n < n; i++) @(negedge clk);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status after reset", status_o, 8'h80);
        chk("R1 convert after reset", convert_o, 0);
        chk("R1 irq after reset", irq_o, 0);
        command(8'h80);
        settle();
        chk("R4 arm on empty list stays idle", status_o, 8'h80);
        chk("R1 no conversions from empty list", conv_n, 0);
    endtask

    task automatic t_one_shot();
        int base;
        base = conv_n;
        command(8'h20);
        put_entry(enc(1, 2'd2, 3'd3, 1));
        put_entry(enc(0, 2'd1, 3'd5, 0));
        put_entry(enc(1, 2'd3, 3'd7, 0));
        continuous_i = 0; eos_irq_en_i = 1;
        command(8'h80);
        @(negedge clk);
        chk("R4 running status after arm", status_o, 8'h40);
        settle();
        chk("R5 start-flag entry waits for tick", conv_n, base);
        tick();
        wait_conv(base + 3);
        settle();
        chk("R6 unflagged entries follow without tick", conv_n, base + 3);
        chk("R2 entry0 fields", log_sel[base], pk(1, 2'd2, 3'd3));
        chk("R2 entry1 fields", log_sel[base+1], pk(0, 2'd1, 3'd5));
        chk("R2 entry2 fields", log_sel[base+2], pk(1, 2'd3, 3'd7));
        chk("R9 one-shot ends idle with eos", status_o, 8'h90);
        chk("R8 irq with enable", irq_o, 1);
        eos_irq_en_i = 0;
        @(negedge clk);
        chk("R8 irq masked by enable", irq_o, 0);
        ack();
        chk("R8 ack clears eos", status_o, 8'h80);
        chk("R7 single-cycle strobe", wide_err, 0);
        chk("R7 selections stable until done", drift_err, 0);
    endtask

    task automatic t_continuous();
        int base;
        base = conv_n;
        command(8'h20);
        put_entry(enc(0, 2'd0, 3'd0, 1));
        put_entry(enc(0, 2'd1, 3'd1, 1));
        continuous_i = 1;
        command(8'h80);
        for (int k = 1; k <= 5; k++) begin
            tick();
            wait_conv(base + k);
            repeat (5) @(negedge clk);
        end
        chk("R9 wrap entry0 again", log_sel[base+2], pk(0, 2'd0, 3'd0));
        chk("R9 wrap entry1 again", log_sel[base+3], pk(0, 2'd1, 3'd1));
        chk("R9 continuous still running", status_o[6], 1);
        command(8'h10);
        @(negedge clk);
        chk("R10 stop returns idle", status_o[7:6], 2'b10);
        base = conv_n;
        tick(); tick();
        settle();
        chk("R10 no strobes after stop", conv_n, base);
        continuous_i = 0;
        ack();
    endtask

    task automatic t_phase();
        int base;
        base = conv_n;
        command(8'h20);
        put_byte(8'hFF);
        command(8'h20);
        put_entry(enc(0, 2'd3, 3'd6, 0));
        command(8'h80);
        wait_conv(base + 1);
        settle();
        chk("R3 one entry after stray byte", conv_n, base + 1);
        chk("R3 byte alignment restored", log_sel[base], pk(0, 2'd3, 3'd6));
        ack();
    endtask

    task automatic t_full();
        int base;
        base = conv_n;
        command(8'h20);
        for (int k = 1; k <= 5; k++) put_entry(enc(0, 2'd0, 3'(k), 0));
        command(8'h80);
        wait_conv(base + 5);
        settle();
        chk("R11 pass limited to depth", conv_n, base + DEPTH);
        chk("R11 last stored entry", log_sel[base+3], pk(0, 2'd0, 3'd4));
        command(8'h80);
        @(negedge clk);
        chk("R8 arm clears eos", status_o[4], 0);
        wait_conv(base + 2 * DEPTH);
        settle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_one_shot();
        t_continuous();
        t_phase();
        t_full();
        finish_run();
    end

endmodule